// File: doc/BRIEF.md
# Dual Alarm Comparator Unit

This block keeps two independent alarm settings and compares them with the time of day supplied by the clock core. A minute-change strobe marks the cycle in which the current minute, hour and weekday are valid. When an enabled alarm's settings match those values, its sticky flag is set. While any flag is set, a shared active-low interrupt line is pulled low. The weekly alarm compares a minute, an hour and a seven-bit set of permitted weekdays. The daily alarm compares only a minute and an hour.

The host reaches the alarm settings, the two enable bits and the two flags through a simple write strobe and a combinational read port. A flag is cleared when the host writes 0 to its bit, or when its enable is cleared. Hours use the same BCD encoding as the clock core, with bit 5 serving as either the PM marker or the tens-of-twenty digit. The block applies no mode conversion, so an alarm hour must be written in the encoding the clock currently uses.

Top module: `alm_dual`

## Requirements
- R1: After reset, every alarm register, both enables and both flags read 0, and `irq_n` is 1.
- R2: Addresses 8h, 9h and Ah hold the weekly alarm's minute (7 bits), hour (6 bits) and weekday mask (7 bits; bit n stands for weekday n). Addresses Bh and Ch hold the daily alarm's minute and hour. Bits above each field read 0. All other addresses below Eh read 0 and ignore writes.
- R3: Address Eh holds the weekly enable in bit 7 and the daily enable in bit 6. Its other bits read 0.
- R4: A `min_tick` cycle sets the weekly flag at the next edge when four conditions hold: the weekly alarm is enabled, its minute equals `cur_min`, its hour equals `cur_hour`, and its mask has bit `cur_wday` set.
- R5: The daily flag sets under the same timing when the daily alarm is enabled and its minute and hour equal the current ones, whatever the weekday.
- R6: Equal time values without `min_tick` set no flag.
- R7: A disabled alarm never sets its flag.
- R8: Address Fh reads the weekly flag in bit 1 and the daily flag in bit 0. Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. A match in the same cycle as a clearing write keeps the flag set.
- R9: Writing 0 to an enable clears its flag. A match in that same cycle does not set the flag.
- R10: `irq_n` is 0 exactly while at least one flag is set. It first falls in the cycle after the matching `min_tick`.
- R11: A `cur_wday` value of 7 never matches the weekly alarm, even with every mask bit set.
- R12: Hour matching compares all six bits. A PM-marked hour such as 21h does not match 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_min | input | 7 | Current BCD minute |
| cur_hour | input | 6 | Current BCD hour, bit 5 is PM or tens-of-twenty |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| min_tick | input | 1 | One-cycle strobe on each minute change |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every cycle, the embedded assertions check four things:
- a flag rises only after an enabled strobe;
- a flag stays set until it is explicitly cleared;
- a disabled alarm holds no flag;
- a falling interrupt follows a strobe.

Match selectivity can only be shown by the directed scenarios. This covers the weekday mask, the out-of-range weekday, the PM bit and the absence of a strobe. The scenarios also cover the register read-back widths and the cycle ordering when a clear and a match coincide.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int MIN_W     = 7;
    localparam int HOUR_W    = 6;
    localparam int DAY_N     = 7;
    localparam int WDAY_W    = 3;
    localparam int NUM_SLOTS = 2;

    localparam logic [ADDR_W-1:0] A_W_MIN  = 4'h8;
    localparam logic [ADDR_W-1:0] A_W_HOUR = 4'h9;
    localparam logic [ADDR_W-1:0] A_W_DAYS = 4'hA;
    localparam logic [ADDR_W-1:0] A_D_MIN  = 4'hB;
    localparam logic [ADDR_W-1:0] A_D_HOUR = 4'hC;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'hE;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'hF;

    localparam int EN_W_BIT  = 7;
    localparam int EN_D_BIT  = 6;
    localparam int FLG_W_BIT = 1;
    localparam int FLG_D_BIT = 0;

    typedef struct packed {
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_N-1:0]  days;
        logic              en;
        logic              flag;
    } slot_t;
endpackage

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_pkg::*;
#(
    parameter bit USE_DAYS = 1'b1
) (
    input  logic [MIN_W-1:0]  set_min,
    input  logic [HOUR_W-1:0] set_hour,
    input  logic [DAY_N-1:0]  set_days,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_day,
    output logic              equal
);
    logic time_eq;
    logic day_ok;

    assign time_eq = (set_min == cur_min) && (set_hour == cur_hour);

    generate
        if (USE_DAYS) begin : g_days
            always_comb begin
                day_ok = 1'b0;
                for (int i = 0; i < DAY_N; i++) begin
                    if (cur_day == WDAY_W'(i)) day_ok = set_days[i];
                end
            end
        end else begin : g_nodays
            assign day_ok = 1'b1;
        end
    endgenerate

    assign equal = time_eq && day_ok;
endmodule

// File: rtl/alm_slot.sv
module alm_slot
    import alm_pkg::*;
#(
    parameter bit USE_DAYS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_day,
    input  logic              wr_min,
    input  logic              wr_hour,
    input  logic              wr_days,
    input  logic              wr_en,
    input  logic              en_wval,
    input  logic              wr_flag,
    input  logic              flag_wval,
    input  logic [DAY_N-1:0]  wdata,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [DAY_N-1:0]  days_o,
    output logic              en_o,
    output logic              flag_o
);
    slot_t s_d, s_q;
    logic  eq;
    logic  hit;
    logic  keep;

    alm_cmp #(.USE_DAYS(USE_DAYS)) u_cmp (
        .set_min  (s_q.min),
        .set_hour (s_q.hour),
        .set_days (s_q.days),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .cur_day  (cur_day),
        .equal    (eq)
    );

    always_comb begin
        s_d = s_q;
        if (wr_min)              s_d.min  = wdata[MIN_W-1:0];
        if (wr_hour)             s_d.hour = wdata[HOUR_W-1:0];
        if (USE_DAYS && wr_days) s_d.days = wdata;
        if (wr_en)               s_d.en   = en_wval;
        hit      = tick && s_q.en && eq;
        keep     = s_q.flag && !(wr_flag && !flag_wval);
        s_d.flag = s_d.en && (keep || hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign min_o  = s_q.min;
    assign hour_o = s_q.hour;
    assign days_o = s_q.days;
    assign en_o   = s_q.en;
    assign flag_o = s_q.flag;

    // R4 R5 R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(tick && s_q.en));

    // R9
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |-> !s_q.flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !(wr_flag && !flag_wval) && !(wr_en && !en_wval)) |=> s_q.flag);
endmodule

// File: rtl/alm_dual.sv
module alm_dual
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              min_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [MIN_W-1:0]  slot_min  [NUM_SLOTS];
    logic [HOUR_W-1:0] slot_hour [NUM_SLOTS];
    logic [DAY_N-1:0]  slot_days [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_en;
    logic [NUM_SLOTS-1:0] slot_flag;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            localparam bit IS_W = (g == 0);
            localparam logic [ADDR_W-1:0] MA = IS_W ? A_W_MIN  : A_D_MIN;
            localparam logic [ADDR_W-1:0] HA = IS_W ? A_W_HOUR : A_D_HOUR;
            localparam int EB = IS_W ? EN_W_BIT  : EN_D_BIT;
            localparam int FB = IS_W ? FLG_W_BIT : FLG_D_BIT;

            alm_slot #(.USE_DAYS(IS_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (min_tick),
                .cur_min   (cur_min),
                .cur_hour  (cur_hour),
                .cur_day   (cur_wday),
                .wr_min    (reg_we && (reg_addr == MA)),
                .wr_hour   (reg_we && (reg_addr == HA)),
                .wr_days   (IS_W && reg_we && (reg_addr == A_W_DAYS)),
                .wr_en     (reg_we && (reg_addr == A_CTRL)),
                .en_wval   (reg_wdata[EB]),
                .wr_flag   (reg_we && (reg_addr == A_FLAG)),
                .flag_wval (reg_wdata[FB]),
                .wdata     (reg_wdata[DAY_N-1:0]),
                .min_o     (slot_min[g]),
                .hour_o    (slot_hour[g]),
                .days_o    (slot_days[g]),
                .en_o      (slot_en[g]),
                .flag_o    (slot_flag[g])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_W_MIN:  reg_rdata = DATA_W'(slot_min[0]);
            A_W_HOUR: reg_rdata = DATA_W'(slot_hour[0]);
            A_W_DAYS: reg_rdata = DATA_W'(slot_days[0]);
            A_D_MIN:  reg_rdata = DATA_W'(slot_min[1]);
            A_D_HOUR: reg_rdata = DATA_W'(slot_hour[1]);
            A_CTRL: begin
                reg_rdata[EN_W_BIT] = slot_en[0];
                reg_rdata[EN_D_BIT] = slot_en[1];
            end
            A_FLAG: begin
                reg_rdata[FLG_W_BIT] = slot_flag[0];
                reg_rdata[FLG_D_BIT] = slot_flag[1];
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq_n = ~|slot_flag;

    // R10
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(min_tick));

    // R2
    wmin_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_W_MIN) |=> slot_min[0] == $past(reg_wdata[MIN_W-1:0]));

    // R2
    dhour_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_D_HOUR) |=> slot_hour[1] == $past(reg_wdata[HOUR_W-1:0]));
endmodule

// File: tb/alm_dual_tb.sv
module alm_dual_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [2:0] cur_wday = '0;
    logic       min_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_dual dut_i (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .min_tick(min_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        check(irq_n == exp, tag, irq_n, exp);
    endtask

    task automatic tick(input logic [6:0] m, input logic [5:0] h, input logic [2:0] d);
        @(negedge clk);
        cur_min = m; cur_hour = h; cur_wday = d; min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1 reset read");
        chk_irq(1'b1, "R1 irq idle");
    endtask

    task automatic t_regs();
        wr(4'h8, 8'hFF); rd(4'h8, 8'h7F, "R2 wmin width");
        wr(4'h9, 8'hFF); rd(4'h9, 8'h3F, "R2 whour width");
        wr(4'hA, 8'hFF); rd(4'hA, 8'h7F, "R2 wdays width");
        wr(4'hB, 8'h59); rd(4'hB, 8'h59, "R2 dmin");
        wr(4'hC, 8'h12); rd(4'hC, 8'h12, "R2 dhour");
        wr(4'hD, 8'hFF); rd(4'hD, 8'h00, "R2 unmapped");
        wr(4'hE, 8'hFF); rd(4'hE, 8'hC0, "R3 ctrl bits");
        wr(4'hE, 8'h00); rd(4'hE, 8'h00, "R3 ctrl clear");
    endtask

    task automatic t_week();
        wr(4'h8, 8'h30); wr(4'h9, 8'h08); wr(4'hA, 8'h2A);
        wr(4'hE, 8'h80);
        tick(7'h30, 6'h08, 3'd2);
        rd(4'hF, 8'h00, "R4 mask bit clear day");
        tick(7'h30, 6'h08, 3'd3);
        rd(4'hF, 8'h02, "R4 weekly match");
        chk_irq(1'b0, "R10 irq low on flag");
        wr(4'hF, 8'h00);
        rd(4'hF, 8'h00, "R8 clear by zero");
        chk_irq(1'b1, "R10 irq released");
        wr(4'hA, 8'h7F);
        tick(7'h30, 6'h08, 3'd7);
        rd(4'hF, 8'h00, "R11 weekday seven");
        tick(7'h31, 6'h08, 3'd3);
        rd(4'hF, 8'h00, "R4 minute differs");
    endtask

    task automatic t_notick();
        @(negedge clk);
        cur_min = 7'h30; cur_hour = 6'h08; cur_wday = 3'd3;
        repeat (4) @(negedge clk);
        rd(4'hF, 8'h00, "R6 no strobe");
        chk_irq(1'b1, "R6 irq idle");
    endtask

    task automatic t_daily();
        wr(4'hB, 8'h45); wr(4'hC, 8'h23);
        wr(4'hE, 8'h40);
        tick(7'h45, 6'h23, 3'd0);
        rd(4'hF, 8'h01, "R5 daily day0");
        wr(4'hF, 8'h00);
        tick(7'h45, 6'h23, 3'd6);
        rd(4'hF, 8'h01, "R5 daily day6");
        wr(4'hF, 8'h00);
    endtask

    task automatic t_disabled();
        wr(4'hE, 8'h00);
        tick(7'h30, 6'h08, 3'd3);
        tick(7'h45, 6'h23, 3'd3);
        rd(4'hF, 8'h00, "R7 disabled no flag");
        chk_irq(1'b1, "R7 irq idle");
        wr(4'hF, 8'hFF);
        rd(4'hF, 8'h00, "R8 write one no set");
    endtask

    task automatic t_flags();
        wr(4'hB, 8'h30); wr(4'hC, 8'h08);
        wr(4'hE, 8'hC0);
        tick(7'h30, 6'h08, 3'd3);
        rd(4'hF, 8'h03, "R8 both flags");
        wr(4'hF, 8'h02);
        rd(4'hF, 8'h02, "R8 clear daily only");
        chk_irq(1'b0, "R10 irq one flag");
        wr(4'hF, 8'h03);
        rd(4'hF, 8'h02, "R8 write one holds");
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'hF; reg_wdata = 8'h00;
        cur_min = 7'h30; cur_hour = 6'h08; cur_wday = 3'd3; min_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; min_tick = 1'b0;
        rd(4'hF, 8'h03, "R8 match beats clear");
        wr(4'hF, 8'h00);
        rd(4'hF, 8'h00, "R8 clear all");
        chk_irq(1'b1, "R10 irq high again");
    endtask

    task automatic t_enclr();
        tick(7'h30, 6'h08, 3'd3);
        wr(4'hF, 8'h02);
        rd(4'hF, 8'h02, "R9 setup");
        wr(4'hE, 8'h40);
        rd(4'hF, 8'h00, "R9 disable clears");
        chk_irq(1'b1, "R9 irq released");
        wr(4'hE, 8'hC0);
        rd(4'hF, 8'h00, "R9 reenable stays clear");
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'hE; reg_wdata = 8'h00;
        cur_min = 7'h30; cur_hour = 6'h08; cur_wday = 3'd3; min_tick = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; min_tick = 1'b0;
        rd(4'hF, 8'h00, "R9 disable beats match");
    endtask

    task automatic t_pm();
        wr(4'h9, 8'h21); wr(4'hE, 8'h80);
        tick(7'h30, 6'h01, 3'd3);
        rd(4'hF, 8'h00, "R12 pm bit differs");
        tick(7'h30, 6'h21, 3'd3);
        rd(4'hF, 8'h02, "R12 pm hour match");
        wr(4'hE, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_week();
        t_notick();
        t_daily();
        t_disabled();
        t_flags();
        t_enclr();
        t_pm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule